// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This unit keeps the condition state produced by a compare operation and uses it to decide conditional jumps. A compare presents two 32-bit operands together with a strobe. The unit compares them as two's-complement numbers and stores three flags: equal, greater and less. The flags then stay unchanged until the next compare.

A jump presents a strobe, a 3-bit condition code, a base register value and a signed 16-bit offset. From the stored flags and the code, the unit decides in the same cycle whether the jump is taken. It also forms the target address as the base plus the sign-extended offset. When the base is zero, the target is the offset alone, which gives an absolute jump. Fetch, decode and pipeline flush are handled elsewhere.

Top module: `cmp_branch_unit`

## Requirements
- R1: When `cmp_valid` is high at a rising clock edge, the flags take equal = (a == b), greater = (signed a > signed b) and less = (signed a < signed b). Jumps see the new flags from the next cycle onward.
- R2: While `cmp_valid` is low, the flags keep their values.
- R3: Reset clears all three flags. Until the first compare, only condition 0 (always) and condition 2 (not equal) are taken.
- R4: The condition codes mean: 0 = always, 1 = equal, 2 = not equal (equal flag clear), 3 = greater, 5 = less.
- R5: Code 4 (greater or equal) is taken when the greater flag or the equal flag is set. Code 6 (less or equal) is taken when the less flag or the equal flag is set.
- R6: Code 7 is never taken.
- R7: `jmp_target` equals `jmp_base` plus `jmp_ofs` sign-extended to 32 bits, modulo 2^32. It is combinational and valid in the same cycle as the jump.
- R8: With `jmp_base` equal to zero, `jmp_target` is the sign-extended offset. This is the absolute jump.
- R9: `jmp_taken` is low whenever `jmp_valid` is low.
- R10: When a compare and a jump arrive in the same cycle, the jump is decided from the flags held before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| jmp_valid | input | 1 | Jump strobe |
| jmp_cond | input | 3 | Condition code (0 always, 1 eq, 2 ne, 3 gt, 4 ge, 5 lt, 6 le, 7 never) |
| jmp_base | input | 32 | Base register value |
| jmp_ofs | input | 16 | Signed jump offset |
| jmp_taken | output | 1 | Jump taken, combinational |
| jmp_target | output | 32 | Jump target address, combinational |

## Verification
The assertions check the following on every cycle:
- The flags do not move without a compare.
- Exactly one flag is set after any compare.
- Code 7 and an absent jump strobe never produce a taken jump.
- Code 0 with a strobe always does.
- A zero base returns the offset in the low target bits.

Only the bench scenarios can show the following:
- The signed ordering across sign boundaries and at the extreme values.
- The exact mapping of each code onto the flags.
- The full sign-extended sum.
- The state just after reset.
- The use of the old flags when a compare and a jump share a cycle.

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              jmp_valid,
  input  logic [2:0]        jmp_cond,
  input  logic [DATA_W-1:0] jmp_base,
  input  logic [OFS_W-1:0]  jmp_ofs,
  output logic              jmp_taken,
  output logic [DATA_W-1:0] jmp_target
);
  localparam int EXT_W = DATA_W - OFS_W;

  logic eq_q, gt_q, lt_q;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q <= 1'b0;
      gt_q <= 1'b0;
      lt_q <= 1'b0;
    end else if (cmp_valid) begin
      eq_q <= (cmp_a == cmp_b);
      gt_q <= ($signed(cmp_a) > $signed(cmp_b));
      lt_q <= ($signed(cmp_a) < $signed(cmp_b));
    end
  end

  always_comb begin
    case (jmp_cond)
      3'd0:    hit = 1'b1;
      3'd1:    hit = eq_q;
      3'd2:    hit = !eq_q;
      3'd3:    hit = gt_q;
      3'd4:    hit = gt_q | eq_q;
      3'd5:    hit = lt_q;
      3'd6:    hit = lt_q | eq_q;
      default: hit = 1'b0;
    endcase
  end

  assign jmp_taken  = jmp_valid & hit;
  assign jmp_target = jmp_base + {{EXT_W{jmp_ofs[OFS_W-1]}}, jmp_ofs};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable({eq_q, gt_q, lt_q}));

  p_one_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> $onehot({eq_q, gt_q, lt_q}));

  p_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_cond == 3'd7) |-> !jmp_taken);

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_valid |-> !jmp_taken);

  p_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_valid && jmp_cond == 3'd0) |-> jmp_taken);

  p_abs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_base == '0) |-> (jmp_target[OFS_W-1:0] == jmp_ofs));
endmodule

// File: tb/sim_cmp_branch_unit.sv
`timescale 1ns/1ps
module sim_cmp_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic        jmp_valid = 1'b0;
  logic [2:0]  jmp_cond = '0;
  logic [31:0] jmp_base = '0;
  logic [15:0] jmp_ofs = '0;
  logic        jmp_taken;
  logic [31:0] jmp_target;

  int checks = 0, fails = 0;
  bit m_eq = 0, m_gt = 0, m_lt = 0;

  always #4 clk = ~clk;

  cmp_branch_unit u0 (.clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_a(cmp_a),
    .cmp_b(cmp_b), .jmp_valid(jmp_valid), .jmp_cond(jmp_cond), .jmp_base(jmp_base),
    .jmp_ofs(jmp_ofs), .jmp_taken(jmp_taken), .jmp_target(jmp_target));

  function automatic bit exp_taken(input logic [2:0] c, input bit e, input bit g, input bit l);
    case (c)
      3'd0: return 1'b1;
      3'd1: return e;
      3'd2: return !e;
      3'd3: return g;
      3'd4: return g || e;
      3'd5: return l;
      3'd6: return l || e;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_target(input logic [31:0] b, input logic [15:0] o);
    int signed so;
    so = int'($signed(o));
    return b + 32'(so);
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h8000_0000;
      1: return 32'h7fff_ffff;
      2: return 32'($urandom % 5) - 32'd2;
      3: return 32'hffff_ffff;
      default: return $urandom;
    endcase
  endfunction

  task automatic report(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (cmp_valid) begin
      m_eq = (cmp_a == cmp_b);
      m_gt = ($signed(cmp_a) > $signed(cmp_b));
      m_lt = ($signed(cmp_a) < $signed(cmp_b));
    end
    @(negedge clk);
    cmp_valid = 1'b0;
    jmp_valid = 1'b0;
  endtask

  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
    cmp_valid = 1'b1; cmp_a = a; cmp_b = b;
    tick();
  endtask

  task automatic check_jump(input logic [2:0] c, input logic [31:0] b, input logic [15:0] o, input string req);
    jmp_valid = 1'b1; jmp_cond = c; jmp_base = b; jmp_ofs = o;
    #1;
    report(req, jmp_taken == exp_taken(c, m_eq, m_gt, m_lt), 32'(jmp_taken),
           32'(exp_taken(c, m_eq, m_gt, m_lt)));
    report(req, jmp_target == exp_target(b, o), jmp_target, exp_target(b, o));
    jmp_valid = 1'b0;
    #1;
  endtask

  task automatic all_conds(input string req);
    for (int c = 0; c < 8; c++) check_jump(3'(c), $urandom, 16'($urandom), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: only always and not-equal are taken after reset
    all_conds("R3 reset flags");

    // R9: no strobe means not taken
    jmp_valid = 1'b0; jmp_cond = 3'd0; #1;
    report("R9 gate", jmp_taken == 1'b0, 32'(jmp_taken), 32'd0);

    // R1 / R4 / R5 directed signed corners
    do_cmp(32'h8000_0000, 32'h7fff_ffff); all_conds("R1 min<max");
    do_cmp(32'hffff_ffff, 32'd1);         all_conds("R1 -1<1");
    do_cmp(32'd5, 32'd5);                 all_conds("R5 equal ge/le");
    do_cmp(32'd1, 32'hffff_ffff);         all_conds("R4 1>-1");
    check_jump(3'd7, 32'd0, 16'h0, "R6 never");

    // R2: flags survive idle cycles
    repeat (4) tick();
    all_conds("R2 hold");

    // R8: absolute jumps from a zero base
    check_jump(3'd0, 32'd0, 16'h8000, "R8 absolute neg");
    check_jump(3'd0, 32'd0, 16'h7ffe, "R8 absolute pos");
    // R7: wraparound and negative offset
    check_jump(3'd0, 32'hffff_fffc, 16'h0008, "R7 wrap");
    check_jump(3'd0, 32'h0001_0000, 16'hfffc, "R7 negative ofs");

    // R10: compare and jump in the same cycle use the old flags
    do_cmp(32'd3, 32'd3);
    cmp_valid = 1'b1; cmp_a = 32'd9; cmp_b = 32'd2;
    check_jump(3'd1, 32'd100, 16'd4, "R10 old flags eq");
    check_jump(3'd3, 32'd100, 16'd4, "R10 old flags gt");
    tick();
    check_jump(3'd3, 32'd100, 16'd4, "R10 new flags gt");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 != 0) do_cmp(pick(), pick());
      else tick();
      check_jump(3'($urandom), ($urandom % 5 == 0) ? 32'd0 : pick(), 16'($urandom), "R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule